// File: doc/BRIEF.md
# Three-Wire Memory Card Bus Monitor

This block watches a synchronous three-wire memory-card link: a card reset line, a card clock line and a shared data line. It never drives any of them. All three lines are oversampled on a fast system clock. The monitor finds reset, command-start and command-stop conditions on the lines. It also turns the serial data bits into bytes.

Each finished byte appears for one system-clock cycle on a valid strobe. The strobe comes with the byte value and a 2-bit class tag. The tag tells apart answer-to-reset bytes, command bytes and response data bytes. The class is not fixed by framing: line events switch it. Separate one-cycle pulses report each reset, start and stop event. A framing flag marks any event that throws away a partly received byte.

Every line change shows at the outputs three system-clock cycles after it reaches the pins. That is two synchronizer flops plus the output register. A logic analyser front end or a debug trace buffer would place this block next to the card pins.

Top module: `cardlink_monitor`

## Requirements
- R1: A rising edge on the card reset line gives a one-cycle pulse on evt_reset_o. It discards any partly received bits. Every byte after it carries tag 2'b00 (answer-to-reset) until a start or stop condition is seen.
- R2: A data bit is taken from the data line only on a rising edge of the card clock while the card reset line is low. Card clock edges while card reset is high add no bits.
- R3: Bits fill the byte least significant bit first. The first sampled bit becomes bit 0 of byte_data_o.
- R4: The eighth sampled bit produces one cycle of byte_valid_o, together with the assembled byte and the current tag. The next byte then starts again from bit 0.
- R5: A falling edge on the data line while the card clock is high gives a pulse on evt_start_o. It discards partial bits and sets the tag of the following bytes to 2'b01 (command).
- R6: A rising edge on the data line while the card clock is high gives a pulse on evt_stop_o. It discards partial bits and sets the tag of the following bytes to 2'b10 (response data).
- R7: At most one condition is acted on per system-clock cycle, in the order reset, data bit, start, stop. Suppose a card clock rise and a data-line edge reach the monitor in the same cycle. That cycle counts as a data bit, and no start or stop is reported.
- R8: frame_err_o pulses together with a reset, start or stop pulse exactly when at least one bit of an unfinished byte was pending. It stays low when the bit count was zero.
- R9: While rst is high, and after it is released, all pulses are low, the tag is 2'b00 and the bit count is zero. The first eight bits after release form a complete byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the card clock |
| rst | input | 1 | Synchronous active-high reset of the monitor |
| card_rst_i | input | 1 | Card reset line (asynchronous to clk) |
| card_clk_i | input | 1 | Card clock line (asynchronous to clk) |
| card_io_i | input | 1 | Card data line, observed only |
| byte_valid_o | output | 1 | One-cycle strobe for a completed byte |
| byte_data_o | output | 8 | Completed byte, first bit in bit 0 |
| byte_tag_o | output | 2 | Byte class: 00 answer-to-reset, 01 command, 10 response data |
| evt_reset_o | output | 1 | Card reset event pulse |
| evt_start_o | output | 1 | Command-start event pulse |
| evt_stop_o | output | 1 | Command-stop event pulse |
| frame_err_o | output | 1 | Pulse: the event discarded a partial byte |

## Verification
Two line changes can reach the priority logic in the same synchronized cycle, and this is the hardest case to reach from the ports. The stimulus moves the card clock high and the data line low in the same system-clock cycle. The rule says this must count as a data bit and not as a command start. Start and stop conditions need the card clock high, so normal stimulus would add a stray bit first. To avoid that, the bench raises the card clock while the card reset line is held high. It then drops reset and only after that toggles the data line. This also checks that clock edges during reset add no bits.

// File: rtl/cardlink_pkg.sv
package cardlink_pkg;

  // Line indices inside the synchronized line vector.
  localparam int LN_RST = 0;
  localparam int LN_CLK = 1;
  localparam int LN_IO  = 2;
  localparam int LINES  = 3;

  typedef enum logic [1:0] {
    TAG_ATR  = 2'b00,
    TAG_CMD  = 2'b01,
    TAG_DATA = 2'b10
  } tag_e;

  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_RESET = 3'd1,
    EV_BIT   = 3'd2,
    EV_START = 3'd3,
    EV_STOP  = 3'd4
  } ev_e;

  // Class of the bytes that follow an event.
  function automatic tag_e f_tag_after(ev_e ev, tag_e cur);
    tag_e t;
    case (ev)
      EV_RESET: t = TAG_ATR;
      EV_START: t = TAG_CMD;
      EV_STOP:  t = TAG_DATA;
      default:  t = cur;
    endcase
    return t;
  endfunction

  // True for the events that restart byte assembly.
  function automatic logic f_is_boundary(ev_e ev);
    return (ev == EV_RESET) || (ev == EV_START) || (ev == EV_STOP);
  endfunction

endpackage

// File: rtl/cl_sync.sv
module cl_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] prv_o
);

  localparam int TOP = STAGES - 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
        prev_q  <= chain_q[TOP];
      end
    end

    assign lvl_o[g] = chain_q[TOP];
    assign prv_o[g] = prev_q;
  end

endmodule

// File: rtl/cl_event_arb.sv
module cl_event_arb
  import cardlink_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] lvl_i,
  input  logic [LINES-1:0] prv_i,
  output ev_e              ev_o
);

  logic cond_reset;
  logic cond_bit;
  logic cond_start;
  logic cond_stop;

  assign cond_reset = lvl_i[LN_RST] & ~prv_i[LN_RST];
  assign cond_bit   = ~lvl_i[LN_RST] & lvl_i[LN_CLK] & ~prv_i[LN_CLK];
  assign cond_start = lvl_i[LN_CLK] & ~lvl_i[LN_IO] & prv_i[LN_IO];
  assign cond_stop  = lvl_i[LN_CLK] & lvl_i[LN_IO] & ~prv_i[LN_IO];

  always_comb begin
    if (cond_reset)      ev_o = EV_RESET;
    else if (cond_bit)   ev_o = EV_BIT;
    else if (cond_start) ev_o = EV_START;
    else if (cond_stop)  ev_o = EV_STOP;
    else                 ev_o = EV_NONE;
  end

  // R2: no bit is taken while the card reset level is high
  assert_bit_gated_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_o == EV_BIT) |-> !lvl_i[LN_RST]);

  // R7: a clock rise outranks a same-cycle data-line edge
  assert_bit_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (cond_bit && !cond_reset) |-> (ev_o == EV_BIT));

endmodule

// File: rtl/cl_deser.sv
module cl_deser
  import cardlink_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ev_e               ev_i,
  input  logic              io_lvl_i,
  output logic              byte_valid_o,
  output logic [DATA_W-1:0] byte_data_o,
  output logic [1:0]        byte_tag_o,
  output logic              evt_reset_o,
  output logic              evt_start_o,
  output logic              evt_stop_o,
  output logic              frame_err_o
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  function automatic logic [DATA_W-1:0] f_insert(logic [DATA_W-1:0] acc,
                                                 logic [CNT_W-1:0] idx,
                                                 logic b);
    logic [DATA_W-1:0] r;
    r = acc;
    r[idx] = b;
    return r;
  endfunction

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] acc_q;
  tag_e              tag_q;
  logic [DATA_W-1:0] acc_next;
  logic              last_bit;
  logic              boundary;

  assign acc_next = f_insert(acc_q, cnt_q, io_lvl_i);
  assign last_bit = (ev_i == EV_BIT) && (cnt_q == LAST);
  assign boundary = f_is_boundary(ev_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= '0;
      acc_q        <= '0;
      tag_q        <= TAG_ATR;
      byte_valid_o <= 1'b0;
      byte_data_o  <= '0;
      byte_tag_o   <= TAG_ATR;
      evt_reset_o  <= 1'b0;
      evt_start_o  <= 1'b0;
      evt_stop_o   <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      evt_reset_o  <= (ev_i == EV_RESET);
      evt_start_o  <= (ev_i == EV_START);
      evt_stop_o   <= (ev_i == EV_STOP);
      frame_err_o  <= boundary && (cnt_q != '0);
      tag_q        <= f_tag_after(ev_i, tag_q);
      if (boundary) begin
        cnt_q <= '0;
        acc_q <= '0;
      end else if (last_bit) begin
        byte_valid_o <= 1'b1;
        byte_data_o  <= acc_next;
        byte_tag_o   <= tag_q;
        cnt_q        <= '0;
        acc_q        <= '0;
      end else if (ev_i == EV_BIT) begin
        acc_q <= acc_next;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R1: a reset event restores the answer-to-reset class and bit 0
  assert_reset_tag_R1: assert property (@(posedge clk) disable iff (rst)
    (ev_i == EV_RESET) |=> (tag_q == TAG_ATR && cnt_q == '0));

  // R4: a byte strobe only follows a sampled bit and leaves the count at 0
  assert_byte_after_bit_R4: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> ($past(ev_i) == EV_BIT && cnt_q == '0));

  // R5: a start event selects the command class
  assert_start_tag_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_i == EV_START) |=> (tag_q == TAG_CMD && cnt_q == '0));

  // R6: a stop event selects the response-data class
  assert_stop_tag_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_i == EV_STOP) |=> (tag_q == TAG_DATA && cnt_q == '0));

  // R7: at most one output pulse per cycle
  assert_one_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({byte_valid_o, evt_reset_o, evt_start_o, evt_stop_o}));

  // R8: the framing flag only accompanies a line event
  assert_frame_with_event_R8: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> (evt_reset_o || evt_start_o || evt_stop_o));

  // R9: monitor reset clears outputs and state
  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!byte_valid_o && !frame_err_o && cnt_q == '0 && tag_q == TAG_ATR));

endmodule

// File: rtl/cardlink_monitor.sv
module cardlink_monitor
  import cardlink_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              card_rst_i,
  input  logic              card_clk_i,
  input  logic              card_io_i,
  output logic              byte_valid_o,
  output logic [DATA_W-1:0] byte_data_o,
  output logic [1:0]        byte_tag_o,
  output logic              evt_reset_o,
  output logic              evt_start_o,
  output logic              evt_stop_o,
  output logic              frame_err_o
);

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] prv;
  ev_e              ev;

  always_comb begin
    raw         = '0;
    raw[LN_RST] = card_rst_i;
    raw[LN_CLK] = card_clk_i;
    raw[LN_IO]  = card_io_i;
  end

  cl_sync #(
    .LINES  (LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .raw_i (raw),
    .lvl_o (lvl),
    .prv_o (prv)
  );

  cl_event_arb u_arb (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (lvl),
    .prv_i (prv),
    .ev_o  (ev)
  );

  cl_deser #(
    .DATA_W (DATA_W)
  ) u_deser (
    .clk          (clk),
    .rst          (rst),
    .ev_i         (ev),
    .io_lvl_i     (lvl[LN_IO]),
    .byte_valid_o (byte_valid_o),
    .byte_data_o  (byte_data_o),
    .byte_tag_o   (byte_tag_o),
    .evt_reset_o  (evt_reset_o),
    .evt_start_o  (evt_start_o),
    .evt_stop_o   (evt_stop_o),
    .frame_err_o  (frame_err_o)
  );

endmodule

// File: tb/tb_cardlink_monitor.sv
`timescale 1ns/1ps
module tb_cardlink_monitor;

  localparam int HOLD = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       card_rst = 1'b0;
  logic       card_clk = 1'b0;
  logic       card_io  = 1'b0;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic [1:0] byte_tag;
  logic       evt_reset, evt_start, evt_stop, frame_err;

  int n_tests = 0;
  int n_fail  = 0;
  int n_bytes = 0, n_rst = 0, n_start = 0, n_stop = 0, n_ferr = 0;
  logic [7:0] last_data;
  logic [1:0] last_tag;
  bit   done = 0;

  always #10 clk = ~clk;

  cardlink_monitor dut (
    .clk (clk), .rst (rst),
    .card_rst_i (card_rst), .card_clk_i (card_clk), .card_io_i (card_io),
    .byte_valid_o (byte_valid), .byte_data_o (byte_data), .byte_tag_o (byte_tag),
    .evt_reset_o (evt_reset), .evt_start_o (evt_start), .evt_stop_o (evt_stop),
    .frame_err_o (frame_err)
  );

  // Observe outputs away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (byte_valid) begin
        n_bytes++;
        last_data = byte_data;
        last_tag  = byte_tag;
      end
      if (evt_reset) n_rst++;
      if (evt_start) n_start++;
      if (evt_stop)  n_stop++;
      if (frame_err) n_ferr++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    card_io = b;
    wait_sys(HOLD);
    card_clk = 1'b1;
    wait_sys(HOLD);
    card_clk = 1'b0;
    wait_sys(HOLD);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  // kind: 1 reset only, 2 reset then start, 3 reset then stop.
  // The card clock is raised while card reset is high, so no bit is added.
  task automatic card_event(input int kind);
    card_clk = 1'b0;
    card_io  = (kind == 2);
    wait_sys(HOLD);
    card_rst = 1'b1;
    wait_sys(HOLD);
    card_clk = 1'b1;
    wait_sys(HOLD);
    card_rst = 1'b0;
    wait_sys(HOLD);
    if (kind == 2) card_io = 1'b0;
    if (kind == 3) card_io = 1'b1;
    wait_sys(HOLD);
    card_clk = 1'b0;
    wait_sys(HOLD);
  endtask

  // {kind[1:0], tag[1:0], byte[7:0]}; kind 0 keeps the current class.
  localparam logic [11:0] VEC [8] = '{
    {2'd1, 2'b00, 8'h3B}, {2'd0, 2'b00, 8'h02},
    {2'd2, 2'b01, 8'h30}, {2'd0, 2'b01, 8'h5A},
    {2'd3, 2'b10, 8'hC6}, {2'd0, 2'b10, 8'h81},
    {2'd2, 2'b01, 8'hFF}, {2'd3, 2'b10, 8'h00}
  };

  initial begin
    int b0, r0, s0, p0, f0;
    wait_sys(4);
    // R9: state held in reset
    check(byte_valid == 0 && evt_reset == 0 && frame_err == 0, "R9 reset pulses", byte_valid, 0);
    check(byte_tag == 2'b00, "R9 reset tag", byte_tag, 0);
    rst = 1'b0;
    wait_sys(4);

    // Table walk: R1, R3, R4, R5, R6
    for (int i = 0; i < 8; i++) begin
      b0 = n_bytes; r0 = n_rst; s0 = n_start; p0 = n_stop; f0 = n_ferr;
      if (VEC[i][11:10] != 0) card_event(int'(VEC[i][11:10]));
      send_bits(VEC[i][7:0], 8);
      wait_sys(HOLD);
      check(n_bytes == b0 + 1, "R4 byte count", n_bytes - b0, 1);
      check(last_data == VEC[i][7:0], "R3 byte value", last_data, VEC[i][7:0]);
      check(last_tag == VEC[i][9:8], "R1/R5/R6 byte tag", last_tag, VEC[i][9:8]);
      check(n_rst == r0 + (VEC[i][11:10] != 0 ? 1 : 0), "R1 reset pulses", n_rst - r0,
            VEC[i][11:10] != 0);
      check(n_start == s0 + (VEC[i][11:10] == 2 ? 1 : 0), "R5 start pulses", n_start - s0,
            VEC[i][11:10] == 2);
      check(n_stop == p0 + (VEC[i][11:10] == 3 ? 1 : 0), "R6 stop pulses", n_stop - p0,
            VEC[i][11:10] == 3);
      check(n_ferr == f0, "R8 no framing on clean bytes", n_ferr - f0, 0);
    end

    // R8: reset while three bits are pending
    b0 = n_bytes; f0 = n_ferr;
    send_bits(8'h07, 3);
    card_event(1);
    check(n_ferr == f0 + 1, "R8 framing on partial byte", n_ferr - f0, 1);
    check(n_bytes == b0, "R8 partial byte dropped", n_bytes - b0, 0);
    send_bits(8'hA6, 8);
    wait_sys(HOLD);
    check(last_data == 8'hA6 && last_tag == 2'b00, "R1 clean restart after reset", last_data, 8'hA6);

    // R8: start with a partial byte pending
    f0 = n_ferr; s0 = n_start;
    send_bits(8'h01, 5);
    card_event(2);
    check(n_ferr == f0 + 1 && n_start == s0 + 1, "R8 framing on start", n_ferr - f0, 1);

    // R2: clock pulses while card reset is high add no bits
    b0 = n_bytes; card_io = 1'b1;
    card_rst = 1'b1;
    wait_sys(HOLD);
    for (int i = 0; i < 8; i++) begin
      card_clk = 1'b1; wait_sys(HOLD);
      card_clk = 1'b0; wait_sys(HOLD);
    end
    check(n_bytes == b0, "R2 no byte under card reset", n_bytes - b0, 0);
    card_rst = 1'b0;
    wait_sys(HOLD);
    send_bits(8'h3C, 8);
    wait_sys(HOLD);
    check(n_bytes == b0 + 1 && last_data == 8'h3C, "R2 no bits gathered under reset", last_data, 8'h3C);

    // R7: card clock rise and data-line fall arrive in the same cycle
    b0 = n_bytes; s0 = n_start; p0 = n_stop;
    card_io = 1'b1;
    wait_sys(HOLD);
    card_clk = 1'b1; card_io = 1'b0;
    wait_sys(HOLD);
    card_clk = 1'b0;
    wait_sys(HOLD);
    send_bits(8'h7F, 7);
    wait_sys(HOLD);
    check(n_start == s0 && n_stop == p0, "R7 no start on simultaneous edge", n_start - s0, 0);
    check(n_bytes == b0 + 1 && last_data == 8'hFE, "R7 edge counted as bit", last_data, 8'hFE);

    // R9: monitor reset in the middle of a byte
    send_bits(8'h0F, 4);
    @(negedge clk); rst = 1'b1;
    wait_sys(3);
    check(byte_valid == 0 && evt_reset == 0 && evt_start == 0 && evt_stop == 0,
          "R9 pulses low in reset", byte_valid, 0);
    check(byte_tag == 2'b00, "R9 tag after reset", byte_tag, 0);
    rst = 1'b0;
    wait_sys(4);
    b0 = n_bytes;
    send_bits(8'h96, 8);
    wait_sys(HOLD);
    check(n_bytes == b0 + 1 && last_data == 8'h96 && last_tag == 2'b00,
          "R9 full byte after release", last_data, 8'h96);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule